// File: doc/BRIEF.md
# Self-Scrubbing Triplicated Register

This block stores one data word in three separate flip-flop copies and keeps those copies in agreement by itself. Each copy has its own majority voter, and every voter reads all three copies. On every clock edge, a copy reloads from its own voter unless a write is in progress. A single corrupted copy is therefore repaired at the next edge, and upsets cannot build up across the copies over many cycles.

A fourth voter, separate from the three refresh voters, drives the data output. No one voter is then the only path to the result. A combinational flag reports any cycle in which the three copies differ.

For test, an injection mask and a copy selector let the bench flip chosen bits of one copy as that copy loads. This imitates a single-event upset, and the repair on the following edge can be observed at the ports.

Top module: `tmrScrubReg`

## Requirements
- R1: While the active-low reset `rstN` is low, all three copies are cleared to zero, so `dataOut` is 0 and `mismatch` is 0.
- R2: When `wrEn` is high at a clock edge, all three copies load `dataIn`, and `dataOut` shows it after that edge.
- R3: When `wrEn` is low and no copy is selected for injection, `dataOut` keeps its value from edge to edge.
- R4: Each voter output bit is 1 exactly when at least two of the three copy bits are 1, so one corrupted copy never changes `dataOut`.
- R5: `injSel` values 0, 1 and 2 select copy 0, 1 or 2. At the next edge, the bits set in `injMask` are flipped in the value that the selected copy loads, for that edge only.
- R6: A copy corrupted at one edge is restored at the following edge when no injection takes place, so `mismatch` returns to 0.
- R7: Upsets injected into different copies on consecutive edges do not accumulate, and `dataOut` stays correct throughout.
- R8: `mismatch` is 1 during every cycle in which the three copies are not all equal, and 0 otherwise.
- R9: If a write and an injection happen at the same edge, the selected copy loads `dataIn` with the mask applied, and `dataOut` equals `dataIn`.
- R10: `injSel` = 3 selects no copy, so a nonzero mask with that selector has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Load `dataIn` into all copies |
| dataIn | input | WIDTH | Word to store |
| injSel | input | 2 | Copy to corrupt (0 to 2), or 3 for none |
| injMask | input | WIDTH | Bits to flip in the selected copy |
| dataOut | output | WIDTH | Majority-voted stored word |
| mismatch | output | 1 | The copies disagree this cycle |

## Verification
The properties assume that at most one copy is corrupted at any one edge. The single selector field guarantees this, because it cannot name two copies at once. The output-stability and restore properties depend on that assumption: with two copies corrupted at the same edge, a majority would no longer mean anything. The stimulus drives every input on the falling edge and keeps injections to one copy per edge. It includes runs of back-to-back injections into different copies.

// File: rtl/tmrScrubPkg.sv
package tmrScrubPkg;
  localparam int NUM_COPIES = 3;
  localparam logic [1:0] INJ_NONE = 2'd3;

  typedef struct packed {
    logic                  loadNew;
    logic [NUM_COPIES-1:0] injHit;
  } tmrStrobe_t;
endpackage

// File: rtl/tmrVoter.sv
module tmrVoter #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] y
);
  // bitwise two-of-three majority
  always_comb y = (a & b) | (b & c) | (a & c);
endmodule

// File: rtl/tmrScrubCtrl.sv
module tmrScrubCtrl
  import tmrScrubPkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] injSel,
  output tmrStrobe_t strobe
);
  always_comb strobe.loadNew = wrEn;

  for (genvar k = 0; k < NUM_COPIES; k++) begin : gSel
    always_comb strobe.injHit[k] = (injSel == 2'(k)) && (injSel != INJ_NONE);
  end
endmodule

// File: rtl/tmrScrubData.sv
module tmrScrubData
  import tmrScrubPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] injMask,
  output logic [WIDTH-1:0] copyQ [NUM_COPIES],
  output logic [WIDTH-1:0] dataOut,
  output logic             mismatch
);
  logic [WIDTH-1:0] votedQ [NUM_COPIES];
  logic [WIDTH-1:0] nextQ  [NUM_COPIES];

  for (genvar k = 0; k < NUM_COPIES; k++) begin : gCopy
    tmrVoter #(.WIDTH(WIDTH)) uRefreshVote (
      .a(copyQ[0]), .b(copyQ[1]), .c(copyQ[2]), .y(votedQ[k])
    );

    always_comb begin
      nextQ[k] = strobe.loadNew ? dataIn : votedQ[k];
      if (strobe.injHit[k]) nextQ[k] = nextQ[k] ^ injMask;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) copyQ[k] <= '0;
      else       copyQ[k] <= nextQ[k];
    end
  end

  tmrVoter #(.WIDTH(WIDTH)) uOutVote (
    .a(copyQ[0]), .b(copyQ[1]), .c(copyQ[2]), .y(dataOut)
  );

  always_comb mismatch = (copyQ[0] != copyQ[1]) || (copyQ[1] != copyQ[2]);
endmodule

// File: rtl/tmrScrubReg.sv
module tmrScrubReg
  import tmrScrubPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [1:0]       injSel,
  input  logic [WIDTH-1:0] injMask,
  output logic [WIDTH-1:0] dataOut,
  output logic             mismatch
);
  tmrStrobe_t       strobe;
  logic [WIDTH-1:0] copyQ [NUM_COPIES];

  tmrScrubCtrl uCtrl (
    .wrEn(wrEn), .injSel(injSel), .strobe(strobe)
  );

  tmrScrubData #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .injMask(injMask), .copyQ(copyQ), .dataOut(dataOut), .mismatch(mismatch)
  );
endmodule

// File: rtl/tmrScrubChk.sv
module tmrScrubChk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [WIDTH-1:0] dataIn,
  input logic [1:0]       injSel,
  input logic [WIDTH-1:0] injMask,
  input logic [WIDTH-1:0] dataOut,
  input logic             mismatch,
  input logic [WIDTH-1:0] copy0,
  input logic [WIDTH-1:0] copy1,
  input logic [WIDTH-1:0] copy2
);
  // R2: a clean write lands in every copy
  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && injSel == 2'd3) |=>
      (copy0 == $past(dataIn) && copy1 == $past(dataIn) && copy2 == $past(dataIn)));

  // R3/R4/R7: without a write the voted output holds even under single upsets
  a_r4_output_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(dataOut));

  // R5: a nonzero mask on a real copy leaves the copies in disagreement
  a_r5_inject_visible: assert property (@(posedge clk) disable iff (!rstN)
    (injSel != 2'd3 && injMask != '0) |=> mismatch);

  // R6/R10: an edge without injection leaves all copies equal
  a_r6_restored: assert property (@(posedge clk) disable iff (!rstN)
    (injSel == 2'd3) |=> !mismatch);
endmodule

bind tmrScrubReg tmrScrubChk #(.WIDTH(WIDTH)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .dataIn(dataIn), .injSel(injSel),
  .injMask(injMask), .dataOut(dataOut), .mismatch(mismatch),
  .copy0(copyQ[0]), .copy1(copyQ[1]), .copy2(copyQ[2])
);

// File: tb/tb_tmrScrubReg.sv
module tb_tmrScrubReg;
  localparam int WIDTH = 8;

  typedef struct {
    logic [WIDTH-1:0] out;
    logic             mis;
    string            tag;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b1;
  logic             wrEn = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic [1:0]       injSel = 2'd3;
  logic [WIDTH-1:0] injMask = '0;
  logic [WIDTH-1:0] dataOut;
  logic             mismatch;

  int total = 0;
  int bad = 0;
  expItem_t expQ[$];
  logic [WIDTH-1:0] mdl [3];

  always #10 clk = ~clk;

  tmrScrubReg #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .dataIn(dataIn), .injSel(injSel),
    .injMask(injMask), .dataOut(dataOut), .mismatch(mismatch)
  );

  function automatic logic [WIDTH-1:0] maj(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b,
                                           logic [WIDTH-1:0] c);
    return (a & b) | (b & c) | (a & c);
  endfunction

  task automatic check(string tag, logic [WIDTH-1:0] eo, logic em);
    total++;
    if (dataOut !== eo || mismatch !== em) begin
      bad++;
      $display("FAIL %s: dataOut=%h mismatch=%b expected dataOut=%h mismatch=%b",
               tag, dataOut, mismatch, eo, em);
    end
  endtask

  // driver: drive one edge's inputs and push the expected result after it
  task automatic step(string tag, logic we, logic [WIDTH-1:0] d, logic [1:0] sel,
                      logic [WIDTH-1:0] msk);
    logic [WIDTH-1:0] base;
    expItem_t it;
    @(negedge clk);
    wrEn = we; dataIn = d; injSel = sel; injMask = msk;
    base = we ? d : maj(mdl[0], mdl[1], mdl[2]);
    for (int k = 0; k < 3; k++) mdl[k] = (sel == 2'(k)) ? (base ^ msk) : base;
    it.out = maj(mdl[0], mdl[1], mdl[2]);
    it.mis = !(mdl[0] == mdl[1] && mdl[1] == mdl[2]);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.tag, it.out, it.mis);
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog: cycles=%0d expected done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    #1 rstN = 1'b0;
    for (int k = 0; k < 3; k++) mdl[k] = '0;
    repeat (2) @(negedge clk);
    check("R1 reset clears", '0, 1'b0);
    rstN = 1'b1;

    step("R2 write", 1'b1, 8'hA5, 2'd3, '0);
    step("R3 hold", 1'b0, 8'h00, 2'd3, '0);
    step("R3 hold again", 1'b0, 8'hFF, 2'd3, '0);
    step("R5 R8 inject copy0", 1'b0, 8'h00, 2'd0, 8'h0F);
    step("R6 restore copy0", 1'b0, 8'h00, 2'd3, '0);
    step("R4 R5 inject copy1 all bits", 1'b0, 8'h00, 2'd1, 8'hFF);
    step("R6 restore copy1", 1'b0, 8'h00, 2'd3, '0);
    step("R5 inject copy2", 1'b0, 8'h00, 2'd2, 8'h81);
    step("R7 then copy0", 1'b0, 8'h00, 2'd0, 8'h81);
    step("R7 then copy1", 1'b0, 8'h00, 2'd1, 8'h3C);
    step("R7 then copy2", 1'b0, 8'h00, 2'd2, 8'hC3);
    step("R6 settle", 1'b0, 8'h00, 2'd3, '0);
    step("R10 no copy selected", 1'b0, 8'h00, 2'd3, 8'hFF);
    step("R9 write with inject", 1'b1, 8'h3C, 2'd1, 8'h01);
    step("R6 after write inject", 1'b0, 8'h00, 2'd3, '0);
    step("R2 write zero", 1'b1, 8'h00, 2'd3, '0);
    step("R4 inject over zero", 1'b0, 8'h00, 2'd2, 8'h55);
    step("R2 write over mismatch", 1'b1, 8'h96, 2'd3, '0);
    step("R3 final hold", 1'b0, 8'h00, 2'd3, '0);
    repeat (3) @(negedge clk);

    rstN = 1'b0;
    #3;
    check("R1 reset mid-run", '0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule